// File: doc/BRIEF.md
# Buffered Flash Word Programmer

This block holds a bank of 32 data words with one valid flag per word. The flags are set by bus writes to the words, and software may also edit them directly. A keyed command starts a buffered write. The engine then walks the flagged words from the lowest index to the highest. It programs each one into flash at the base address plus four times its index, using one request/done handshake per word. Unflagged words are skipped, so their flash locations stay as they were.

Flash programming can only drive bits to 0. A 1 in the data leaves the old bit as it was, so the resulting word is the old word AND the data. The flash answers each done with the word it read back. The engine flags a verify error when a bit that the data asked to clear still reads 1. When the write finishes, or when a protection violation aborts it, the whole valid bitmap is cleared. The data words are kept, so software can set the flags again and program the same data at another base.

The controller has five states. IDLE waits for a command. SCAN picks the lowest pending word, or sees that none is left. PROG holds a request until done. FINISH signals completion. ABORT signals a protection stop. The transitions are:
- IDLE→SCAN on a keyed start.
- IDLE→ABORT on a keyed start with protection asserted.
- SCAN→PROG when a word is pending.
- SCAN→FINISH when none is pending.
- PROG→SCAN on done.
- PROG→ABORT on done with protection asserted.
- FINISH→IDLE and ABORT→IDLE unconditionally.

Top module: `fwb_engine`

## Requirements
- R1: A bus write to byte offset 0x100+4n (n = 0..31) stores the word in slot n and sets valid bit n. A read of that offset returns the stored word.
- R2: The valid bitmap reads and writes at offset 0x030, where bit n belongs to slot n. A write replaces all 32 bits, so software can set or clear any of them.
- R3: A write to offset 0x020 while idle starts a buffered write only when bits 31:16 equal 0xA442 and bit 0 is 1; any other value is ignored. Bit 0 of offset 0x020 reads 1 from the cycle after the start until the engine is idle again.
- R4: The base address is bits 19:0 at offset 0x000. Slot n is programmed at base + 4n.
- R5: Flagged slots are programmed in ascending index order, with exactly one request per slot. The request stays high until done. Unflagged slots get no request and their flash words are unchanged.
- R6: With an empty bitmap, a start completes without any flash request and gives one completion pulse.
- R7: On completion, a one-cycle completion pulse is given and the valid bitmap reads 0. The slot data is kept, so setting the flags again programs the same data at a new base.
- R8: A done whose read-back word has a 1 where the slot data has a 0 gives a one-cycle verify-error pulse, and the sequence goes on. Read-back zeros where the data has ones are accepted, because the result is the old word AND the data.
- R9: Protection asserted at the start or with any done ends the operation: one abort pulse, bitmap cleared, no further requests, and no completion pulse. A verify failure on the aborted word raises no verify-error pulse.
- R10: While busy, bus writes to the slots, the bitmap and the base register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 9 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| fl_req | output | 1 | Word program request |
| fl_addr | output | 20 | Flash byte address of the word |
| fl_wdata | output | 32 | Word to program |
| fl_done | input | 1 | Program done |
| fl_rdata | input | 32 | Word read back with done |
| fl_prot | input | 1 | Protection violation |
| op_done | output | 1 | Completion pulse |
| op_verr | output | 1 | Verify-error pulse |
| op_abort | output | 1 | Protection-abort pulse |

## Verification
A protection violation and a failed verify can land on the same done edge. The bench sets this up by protecting the first flagged word and making the flash model return a stuck 1 in a bit that word's data clears. The check expects an abort pulse, no verify-error pulse, no completion pulse and an empty bitmap. A keyed start and a bus write can also meet the engine while it is busy. The bench writes a slot and the base register during a run, then reads both back unchanged.

// File: rtl/fwb_pkg.sv
package fwb_pkg;
    localparam int REG_AW = 9;
    localparam logic [REG_AW-1:0] OFF_BASE  = 9'h000;
    localparam logic [REG_AW-1:0] OFF_CMD   = 9'h020;
    localparam logic [REG_AW-1:0] OFF_VALID = 9'h030;
    localparam logic [REG_AW-1:0] OFF_SLOTS = 9'h100;
    localparam logic [15:0]       CMD_KEY   = 16'hA442;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_PROG,
        ST_FINISH,
        ST_ABORT
    } seq_state_t;
endpackage

// File: rtl/fwb_pick.sv
module fwb_pick #(
    parameter int N    = 32,
    parameter int IDXW = $clog2(N)
) (
    input  logic [N-1:0]    mask,
    output logic            found,
    output logic [IDXW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i]) begin
                found = 1'b1;
                idx   = IDXW'(i);
            end
        end
    end
endmodule

// File: rtl/fwb_store.sv
module fwb_store #(
    parameter int N    = 32,
    parameter int DW   = 32,
    parameter int IDXW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            slot_we,
    input  logic [IDXW-1:0] slot_idx,
    input  logic [DW-1:0]   slot_wdata,
    input  logic            flags_we,
    input  logic [N-1:0]    flags_wdata,
    input  logic            flags_clr,
    output logic [DW-1:0]   slots [N],
    output logic [N-1:0]    flags
);
    for (genvar g = 0; g < N; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slots[g] <= '0;
            else if (slot_we && slot_idx == IDXW'(g))
                slots[g] <= slot_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flags <= '0;
        else if (flags_clr)
            flags <= '0;
        else if (flags_we)
            flags <= flags_wdata;
        else if (slot_we)
            flags <= flags | (N'(1) << slot_idx);
    end
endmodule

// File: rtl/fwb_seq.sv
module fwb_seq
    import fwb_pkg::*;
#(
    parameter int N    = 32,
    parameter int DW   = 32,
    parameter int AW   = 20,
    parameter int IDXW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [N-1:0]  flags,
    input  logic [DW-1:0] slots [N],
    input  logic [AW-1:0] base,
    output logic          busy,
    output logic          flags_clr,
    output logic          fl_req,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_wdata,
    input  logic          fl_done,
    input  logic [DW-1:0] fl_rdata,
    input  logic          fl_prot,
    output logic          op_done,
    output logic          op_verr,
    output logic          op_abort
);
    seq_state_t      state_q, state_d;
    logic [N-1:0]    pend_q;
    logic [IDXW-1:0] idx_q;
    logic            verr_q;
    logic            pick_found;
    logic [IDXW-1:0] pick_idx;

    fwb_pick #(.N(N), .IDXW(IDXW)) u_pick (
        .mask  (pend_q),
        .found (pick_found),
        .idx   (pick_idx)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = fl_prot ? ST_ABORT : ST_SCAN;
            ST_SCAN:   state_d = pick_found ? ST_PROG : ST_FINISH;
            ST_PROG:   if (fl_done) state_d = fl_prot ? ST_ABORT : ST_SCAN;
            ST_FINISH: state_d = ST_IDLE;
            ST_ABORT:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            idx_q  <= '0;
            verr_q <= 1'b0;
        end else begin
            verr_q <= 1'b0;
            if (state_q == ST_IDLE && start)
                pend_q <= flags;
            if (state_q == ST_SCAN && pick_found)
                idx_q <= pick_idx;
            if (state_q == ST_PROG && fl_done) begin
                pend_q[idx_q] <= 1'b0;
                verr_q <= !fl_prot && ((fl_rdata & ~slots[idx_q]) != '0);
            end
        end
    end

    always_comb begin
        busy      = (state_q != ST_IDLE);
        fl_req    = (state_q == ST_PROG);
        fl_addr   = base + (AW'(idx_q) << 2);
        fl_wdata  = slots[idx_q];
        op_done   = (state_q == ST_FINISH);
        op_abort  = (state_q == ST_ABORT);
        flags_clr = op_done || op_abort;
        op_verr   = verr_q;
    end

    // R5: a request always targets a slot still pending
    a_r5_req_pending: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req |-> pend_q[idx_q]);
    // R6: scanning an empty pending set completes next cycle
    a_r6_empty_done: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && pend_q == '0) |=> op_done);
    // R7: bitmap is empty after completion
    a_r7_flags_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> (flags == '0));
    // R9: protection on done stops requests and aborts
    a_r9_abort_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req && fl_done && fl_prot) |=> (!fl_req && op_abort && !op_verr));
endmodule

// File: rtl/fwb_engine.sv
module fwb_engine
    import fwb_pkg::*;
#(
    parameter int N_SLOTS = 32,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [REG_AW-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                fl_req,
    output logic [ADDR_W-1:0]   fl_addr,
    output logic [DATA_W-1:0]   fl_wdata,
    input  logic                fl_done,
    input  logic [DATA_W-1:0]   fl_rdata,
    input  logic                fl_prot,
    output logic                op_done,
    output logic                op_verr,
    output logic                op_abort
);
    // slot window must be aligned to its own size: N_SLOTS a power of two, 4*N_SLOTS <= 256
    localparam int IDXW = $clog2(N_SLOTS);
    localparam int WINL = IDXW + 2;

    logic [DATA_W-1:0] slots [N_SLOTS];
    logic [N_SLOTS-1:0] flags;
    logic [ADDR_W-1:0]  base_q;
    logic busy, flags_clr;
    logic in_slots, slot_we, flags_we, start;
    logic [IDXW-1:0] slot_idx;

    always_comb begin
        in_slots = (bus_addr[REG_AW-1:WINL] == OFF_SLOTS[REG_AW-1:WINL])
                   && (bus_addr[1:0] == 2'b00);
        slot_idx = bus_addr[WINL-1:2];
        slot_we  = bus_wr && !busy && in_slots;
        flags_we = bus_wr && !busy && (bus_addr == OFF_VALID);
        start    = bus_wr && (bus_addr == OFF_CMD)
                   && (bus_wdata[31:16] == CMD_KEY) && bus_wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            base_q <= '0;
        else if (bus_wr && !busy && bus_addr == OFF_BASE)
            base_q <= bus_wdata[ADDR_W-1:0];
    end

    fwb_store #(.N(N_SLOTS), .DW(DATA_W), .IDXW(IDXW)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .slot_we     (slot_we),
        .slot_idx    (slot_idx),
        .slot_wdata  (bus_wdata),
        .flags_we    (flags_we),
        .flags_wdata (bus_wdata[N_SLOTS-1:0]),
        .flags_clr   (flags_clr),
        .slots       (slots),
        .flags       (flags)
    );

    fwb_seq #(.N(N_SLOTS), .DW(DATA_W), .AW(ADDR_W), .IDXW(IDXW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .flags     (flags),
        .slots     (slots),
        .base      (base_q),
        .busy      (busy),
        .flags_clr (flags_clr),
        .fl_req    (fl_req),
        .fl_addr   (fl_addr),
        .fl_wdata  (fl_wdata),
        .fl_done   (fl_done),
        .fl_rdata  (fl_rdata),
        .fl_prot   (fl_prot),
        .op_done   (op_done),
        .op_verr   (op_verr),
        .op_abort  (op_abort)
    );

    always_comb begin
        bus_rdata = '0;
        if (in_slots)
            bus_rdata = slots[slot_idx];
        else if (bus_addr == OFF_BASE)
            bus_rdata = DATA_W'(base_q);
        else if (bus_addr == OFF_CMD)
            bus_rdata = DATA_W'(busy);
        else if (bus_addr == OFF_VALID)
            bus_rdata = DATA_W'(flags);
    end

    // R3: a wrong key never leaves the idle state
    a_r3_bad_key: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && bus_wr && bus_addr == OFF_CMD && bus_wdata[31:16] != CMD_KEY) |=> !busy);
    // R10: base register holds while busy
    a_r10_base_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_wr && bus_addr == OFF_BASE) |=> $stable(base_q));
endmodule

// File: tb/test_fwb_engine.sv
module test_fwb_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        fl_req, fl_done, fl_prot;
    logic [19:0] fl_addr;
    logic [31:0] fl_wdata, fl_rdata;
    logic        op_done, op_verr, op_abort;

    always #2.5 clk = ~clk;

    fwb_engine i_fwb_engine (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fl_req(fl_req),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_done(fl_done),
        .fl_rdata(fl_rdata), .fl_prot(fl_prot), .op_done(op_done),
        .op_verr(op_verr), .op_abort(op_abort)
    );

    // flash model: 256 words, AND programming, optional stuck-at-1 bits
    logic [31:0] mem [256];
    logic [31:0] expm [256];
    logic        done_q = 1'b0;
    logic [31:0] rd_q = '0;
    logic [31:0] stuck = '0;
    logic        prot_start = 1'b0;
    logic        prot_on = 1'b0;
    logic [19:0] prot_addr = '0;
    logic [19:0] cur_base = '0;
    int          log_idx [64];
    int          log_n = 0;
    int          n_done = 0, n_verr = 0, n_abort = 0;

    assign fl_done  = done_q;
    assign fl_rdata = rd_q;
    assign fl_prot  = prot_start || (prot_on && fl_req && fl_addr == prot_addr);

    always @(posedge clk) begin
        if (fl_req && !done_q) begin
            done_q <= 1'b1;
            rd_q   <= (mem[fl_addr[9:2]] & fl_wdata) | stuck;
            if (!fl_prot) mem[fl_addr[9:2]] <= mem[fl_addr[9:2]] & fl_wdata;
            if (log_n < 64) log_idx[log_n] <= int'((fl_addr - cur_base) >> 2);
            log_n <= log_n + 1;
        end else begin
            done_q <= 1'b0;
        end
        if (op_done)  n_done  <= n_done + 1;
        if (op_verr)  n_verr  <= n_verr + 1;
        if (op_abort) n_abort <= n_abort + 1;
    end

    int total = 0, bad = 0;
    int cycles = 0;
    logic [31:0] sb [32];
    logic [31:0] sv = '0;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog act=%0d exp=%0d", cycles, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] d;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            rd(9'h020, d);
            if (d[0] == 1'b0) break;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic put_slot(input int n, input logic [31:0] d);
        wr(9'h100 + 9'(4 * n), d);
        sb[n] = d;
        sv[n] = 1'b1;
    endtask

    task automatic start_op(input logic [19:0] base);
        wr(9'h000, 32'(base));
        cur_base = base;
        log_n = 0; n_done = 0; n_verr = 0; n_abort = 0;
        wr(9'h020, 32'hA442_0001);
    endtask

    // expected flash image; abort_at = -1 for none
    function automatic void apply_exp(input logic [19:0] base, input int abort_at);
        for (int n = 0; n < 32; n++) begin
            if (sv[n]) begin
                if (n == abort_at) break;
                expm[(base >> 2) + 20'(n)] = expm[(base >> 2) + 20'(n)] & sb[n];
            end
        end
    endfunction

    function automatic int count_valid(input logic [31:0] m, input int abort_at);
        int c = 0;
        for (int n = 0; n < 32; n++)
            if (m[n] && (abort_at < 0 || n <= abort_at)) c++;
        return c;
    endfunction

    function automatic int mem_mismatch();
        int c = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== expm[i]) c++;
        return c;
    endfunction

    function automatic bit log_ascending(input logic [31:0] m);
        int k = 0;
        for (int n = 0; n < 32; n++) begin
            if (m[n]) begin
                if (k >= log_n || log_idx[k] != n) return 1'b0;
                k++;
            end
        end
        return k == log_n;
    endfunction

    initial begin
        logic [31:0] d;
        void'($urandom(32'd4242));
        for (int i = 0; i < 256; i++) begin mem[i] = 32'hFFFF_FFFF; expm[i] = 32'hFFFF_FFFF; end
        for (int i = 0; i < 32; i++) sb[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        rd(9'h030, d); chk(d == 0, "R2 reset valid", d, 0);
        rd(9'h020, d); chk(d == 0, "R3 reset idle", d, 0);
        rd(9'h000, d); chk(d == 0, "R4 reset base", d, 0);
        chk(fl_req == 0, "R5 reset req", 32'(fl_req), 0);

        // R1 slot store and flag set
        put_slot(3, 32'h1234_5678);
        rd(9'h10C, d); chk(d == 32'h1234_5678, "R1 slot readback", d, 32'h1234_5678);
        rd(9'h030, d); chk(d == 32'h8, "R1 valid set", d, 32'h8);

        // R2 bitmap edit
        wr(9'h030, 32'hA000_0001);
        rd(9'h030, d); chk(d == 32'hA000_0001, "R2 valid write", d, 32'hA000_0001);
        wr(9'h030, 32'h0);
        sv = '0;
        rd(9'h030, d); chk(d == 0, "R2 valid clear", d, 0);

        // R3 bad key / zero bit: no start
        put_slot(0, 32'h0F0F_0F0F);
        wr(9'h020, 32'hA443_0001);
        rd(9'h020, d); chk(d == 0, "R3 wrong key ignored", d, 0);
        wr(9'h020, 32'hA442_0000);
        rd(9'h020, d); chk(d == 0, "R3 bit0 clear ignored", d, 0);
        chk(log_n == 0, "R3 no request", 32'(log_n), 0);

        // R3/R4/R5/R7 directed run at base 0x40, slots 0,3
        sv = 32'h9; wr(9'h030, sv);
        start_op(20'h40);
        rd(9'h020, d); chk(d[0] == 1'b1, "R3 busy readback", d, 1);
        apply_exp(20'h40, -1);
        wait_idle();
        chk(mem_mismatch() == 0, "R4 image", 32'(mem_mismatch()), 0);
        chk(log_ascending(sv), "R5 order", 32'(log_n), 2);
        chk(n_done == 1, "R7 done pulse", 32'(n_done), 1);
        rd(9'h030, d); chk(d == 0, "R7 flags cleared", d, 0);
        rd(9'h10C, d); chk(d == 32'h1234_5678, "R7 data kept", d, 32'h1234_5678);

        // R7 re-arm same data new base
        sv = 32'h9; wr(9'h030, sv);
        start_op(20'h200);
        apply_exp(20'h200, -1);
        wait_idle();
        chk(mem_mismatch() == 0, "R7 rearm image", 32'(mem_mismatch()), 0);

        // R6 empty bitmap
        sv = '0;
        start_op(20'h80);
        wait_idle();
        chk(n_done == 1 && log_n == 0, "R6 empty done", 32'(log_n), 0);

        // R8 verify error: stuck bit 4, slot 0 data bit4=0, slot 3 data bit4=1
        stuck = 32'h10;
        put_slot(0, 32'hFFFF_FFEF);
        put_slot(3, 32'hFFFF_FFFF);
        start_op(20'h300);
        apply_exp(20'h300, -1);
        wait_idle();
        chk(n_verr == 1, "R8 verify pulses", 32'(n_verr), 1);
        chk(n_done == 1, "R8 sequence continues", 32'(n_done), 1);
        stuck = '0;

        // R9 protection at start
        put_slot(1, 32'h0);
        prot_start = 1'b1;
        start_op(20'h100);
        prot_start = 1'b0;
        wait_idle();
        chk(n_abort == 1 && log_n == 0, "R9 start abort", 32'(log_n), 0);
        chk(mem_mismatch() == 0, "R9 start untouched", 32'(mem_mismatch()), 0);
        rd(9'h030, d); chk(d == 0, "R9 flags cleared", d, 0);
        sv = '0;

        // R9 protection mid sequence at slot 5
        for (int n = 2; n < 8; n++) put_slot(n, 32'h5555_0000 | 32'(n));
        prot_on = 1'b1; prot_addr = 20'h180 + 20'(4 * 5);
        start_op(20'h180);
        apply_exp(20'h180, 5);
        wait_idle();
        chk(n_abort == 1 && n_done == 0, "R9 mid abort", 32'(n_abort), 1);
        chk(log_n == count_valid(sv, 5), "R9 stop requests", 32'(log_n), 32'(count_valid(sv, 5)));
        chk(mem_mismatch() == 0, "R9 mid image", 32'(mem_mismatch()), 0);

        // R9 abort and verify failure on the same done: abort wins
        sv = '0;
        stuck = 32'h1;
        put_slot(0, 32'hFFFF_FFFE);
        prot_addr = 20'h280;
        start_op(20'h280);
        wait_idle();
        chk(n_abort == 1 && n_verr == 0 && n_done == 0, "R9 abort beats verify", 32'(n_verr), 0);
        prot_on = 1'b0; stuck = '0; sv = '0;

        // R10 writes while busy ignored
        put_slot(9, 32'hCAFE_0000);
        start_op(20'h0);
        wr(9'h124, 32'h1111_1111);
        wr(9'h000, 32'h3FC);
        apply_exp(20'h0, -1);
        wait_idle();
        rd(9'h124, d); chk(d == 32'hCAFE_0000, "R10 slot locked", d, 32'hCAFE_0000);
        rd(9'h000, d); chk(d == 0, "R10 base locked", d, 0);
        chk(mem_mismatch() == 0, "R10 image", 32'(mem_mismatch()), 0);
        sv = '0;

        // random runs
        for (int it = 0; it < 16; it++) begin
            logic [19:0] b;
            int nw;
            b  = 20'(($urandom % 225) * 4);
            nw = 1 + int'($urandom % 10);
            for (int k = 0; k < nw; k++) put_slot(int'($urandom % 32), $urandom);
            if ($urandom % 2) begin
                sv = sv & $urandom;
                wr(9'h030, sv);
            end
            start_op(b);
            apply_exp(b, -1);
            wait_idle();
            chk(mem_mismatch() == 0, "R4 random image", 32'(mem_mismatch()), 0);
            chk(log_ascending(sv), "R5 random order", 32'(log_n), 32'(count_valid(sv, -1)));
            chk(n_done == 1, "R7 random done", 32'(n_done), 1);
            rd(9'h030, d); chk(d == 0, "R7 random cleared", d, 0);
            sv = '0;
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule